// File: doc/BRIEF.md
# Coprocessor Reset and Power-On Controller

This block governs the run state of one auxiliary processor core through three registers on a simple synchronous write port with a combinational read. A set-only trigger register holds the reset request for the core. A clear-only release register removes that request. A control/status register carries three things: a software hold request, a self-clearing enable, and three read-only status flags. These flags show that the core is in reset, that the reset came from the trigger, and that the core is being held.

Writing the trigger bit puts the core into reset. If the hold request is set when the reset arrives, the core is also held and a power-off is issued. When the reset is released, a core that is not held powers up at once. A held core stays off until software writes the enable bit. The core itself is represented by a run-state level and by single-cycle power-on and power-off pulses.

Top module: `corepwr_ctl`

## Requirements
- R1: After controller reset the control/status register (offset 0x160) reads 0x7FE, the trigger register (offset 0x220) reads 0x1FFF, `core_run` is 0 and neither pulse is active.
- R2: A write to the trigger register sets every bit written as 1 within the low 13 bits; zeros and bits 13 and above have no effect. A 1 in bit 9 puts the core into reset: control bit 8 (in reset) and bit 10 (reset from trigger) become 1.
- R3: A write to the release register (offset 0x224) clears those of the low 13 trigger bits that are written as 1 and are currently set. A release of bit 9 while it is set clears control bit 10. The release register reads 0.
- R4: If the trigger of R2 arrives while control bit 1 (hold request) is 1, control bit 9 (held) becomes 1. A running core is then powered off: one `pwr_off_pulse` and `core_run` falls.
- R5: Writing 0 to control bit 1 clears control bit 9.
- R6: A release of R3 while control bit 9 is 0 clears control bit 8 and powers the core on.
- R7: A release of R3 while control bit 9 is 1 leaves the core off and control bit 8 at 1.
- R8: Writing 1 to control bit 0 clears control bits 8, 9 and 10 and powers the core on. Bit 0 always reads 0.
- R9: A power-on raises `pwr_on_pulse` for exactly one cycle, in the cycle after the causing write, and sets `core_run`. A power-on request while `core_run` is 1 gives no pulse.
- R10: Control bits 8 to 10 ignore writes, and control bits 2 to 7 store the written value. Bits 11 and above of the control register read 0. Reads of any other offset return 0, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| core_run | output | 1 | Core powered and running |
| pwr_on_pulse | output | 1 | One-cycle core power-on |
| pwr_off_pulse | output | 1 | One-cycle core power-off |

## Verification
Register state, `core_run` and both pulses change at the clock edge that captures a write. The pulses are therefore due in the cycle right after the write cycle, and the bench also checks that the power-on pulse has dropped one cycle later. Read data is combinational from the current state, so a read check is due in the same cycle the offset is presented. Each driver call records the cycle index at which its expected item falls due. The monitor compares items only at falling edges whose index matches, while the driver changes inputs just after rising edges.

// File: rtl/corepwr_pkg.sv
package corepwr_pkg;

    // control/status word, bit 0 (enable) is never stored
    typedef struct packed {
        logic       src;     // bit 10: reset came from trigger register
        logic       hold;    // bit 9 : core held in reset
        logic       in_rst;  // bit 8 : core in reset
        logic [6:0] cfg;     // bits 7..1, cfg[0] is the hold request
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t) + 1;

    localparam ctl_t CTL_RST = '{src: 1'b1, hold: 1'b1, in_rst: 1'b1, cfg: 7'h7F};

    typedef struct packed {
        logic on;
        logic off;
        logic run;
    } pwr_t;

    function automatic logic [CTL_W-1:0] ctl_word(input ctl_t c);
        return {c, 1'b0};
    endfunction

endpackage

// File: rtl/corepwr_decode.sv
module corepwr_decode #(
    parameter int                 ADDR_W   = 12,
    parameter int                 DATA_W   = 32,
    parameter int                 TRIG_W   = 13,
    parameter int                 CTL_W    = 11,
    parameter logic [ADDR_W-1:0]  OFS_CTL  = 'h160,
    parameter logic [ADDR_W-1:0]  OFS_TRIG = 'h220,
    parameter logic [ADDR_W-1:0]  OFS_CLR  = 'h224
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TRIG_W-1:0] trig_q,
    input  logic [CTL_W-1:0]  ctl_q,
    output logic              ctl_we,
    output logic              trig_we,
    output logic              clr_we,
    output logic [DATA_W-1:0] rdata
);
    logic hit_ctl, hit_trig;

    assign hit_ctl  = (addr == OFS_CTL);
    assign hit_trig = (addr == OFS_TRIG);

    assign ctl_we  = we && hit_ctl;
    assign trig_we = we && hit_trig;
    assign clr_we  = we && (addr == OFS_CLR);

    always_comb begin
        rdata = '0;
        if (hit_trig)     rdata = DATA_W'(trig_q);
        else if (hit_ctl) rdata = DATA_W'(ctl_q);
    end
endmodule

// File: rtl/corepwr_trig.sv
module corepwr_trig #(
    parameter int                TRIG_W   = 13,
    parameter int                CORE_BIT = 9,
    parameter logic [TRIG_W-1:0] RST_VAL  = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [TRIG_W-1:0] wdata,
    output logic [TRIG_W-1:0] trig_q,
    output logic              assert_evt,
    output logic              release_evt
);
    logic [TRIG_W-1:0] clr_hit;

    assign clr_hit     = clr_we ? (wdata & trig_q) : '0;
    assign assert_evt  = set_we && wdata[CORE_BIT];
    assign release_evt = clr_hit[CORE_BIT];

    always_ff @(posedge clk) begin
        if (rst)          trig_q <= RST_VAL;
        else if (set_we)  trig_q <= trig_q | wdata;
        else if (clr_we)  trig_q <= trig_q & ~clr_hit;
    end

    // R2
    trig_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((trig_q & $past(wdata)) == $past(wdata)));

    // R3
    trig_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((trig_q & $past(wdata)) == '0));
endmodule

// File: rtl/corepwr_core.sv
module corepwr_core
    import corepwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [7:0]       wdata,
    input  logic             assert_evt,
    input  logic             release_evt,
    output logic [CTL_W-1:0] ctl_rd,
    output pwr_t             pwr
);
    ctl_t c_q, c_n;
    pwr_t p_n;

    always_comb begin
        c_n   = c_q;
        p_n   = '{on: 1'b0, off: 1'b0, run: pwr.run};
        if (ctl_we) begin
            c_n.cfg = wdata[7:1];
            if (!wdata[1]) c_n.hold = 1'b0;
            if (wdata[0]) begin
                c_n.hold   = 1'b0;
                c_n.in_rst = 1'b0;
                c_n.src    = 1'b0;
                if (!pwr.run) begin
                    p_n.run = 1'b1;
                    p_n.on  = 1'b1;
                end
            end
        end else if (assert_evt) begin
            c_n.in_rst = 1'b1;
            c_n.src    = 1'b1;
            if (c_q.cfg[0]) begin
                c_n.hold = 1'b1;
                if (pwr.run) begin
                    p_n.run = 1'b0;
                    p_n.off = 1'b1;
                end
            end
        end else if (release_evt) begin
            c_n.src = 1'b0;
            if (!c_q.hold) begin
                c_n.in_rst = 1'b0;
                if (!pwr.run) begin
                    p_n.run = 1'b1;
                    p_n.on  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= CTL_RST;
            pwr <= '{on: 1'b0, off: 1'b0, run: 1'b0};
        end else begin
            c_q <= c_n;
            pwr <= p_n;
        end
    end

    assign ctl_rd = ctl_word(c_q);

    // R9
    on_single_chk: assert property (@(posedge clk) disable iff (rst)
        pwr.on |=> !pwr.on);

    // R9
    on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        pwr.on |-> (pwr.run && !$past(pwr.run)));

    // R4
    off_edge_chk: assert property (@(posedge clk) disable iff (rst)
        pwr.off |-> (!pwr.run && $past(pwr.run)));

    // R5
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        c_q.hold |-> c_q.cfg[0]);

    // R7
    hold_in_rst_chk: assert property (@(posedge clk) disable iff (rst)
        c_q.hold |-> c_q.in_rst);

    // R2
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pwr.on && pwr.off));
endmodule

// File: rtl/corepwr_ctl.sv
module corepwr_ctl
    import corepwr_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int TRIG_W   = 13,
    parameter int CORE_BIT = 9,
    parameter logic [ADDR_W-1:0] OFS_CTL  = 'h160,
    parameter logic [ADDR_W-1:0] OFS_TRIG = 'h220,
    parameter logic [ADDR_W-1:0] OFS_CLR  = 'h224
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              core_run,
    output logic              pwr_on_pulse,
    output logic              pwr_off_pulse
);
    logic              ctl_we, trig_we, clr_we;
    logic              assert_evt, release_evt;
    logic [TRIG_W-1:0] trig_q;
    logic [CTL_W-1:0]  ctl_rd;
    pwr_t              pwr;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:TRIG_W];

    corepwr_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRIG_W(TRIG_W), .CTL_W(CTL_W),
        .OFS_CTL(OFS_CTL), .OFS_TRIG(OFS_TRIG), .OFS_CLR(OFS_CLR)
    ) dec_i (
        .we(reg_we), .addr(reg_addr), .trig_q(trig_q), .ctl_q(ctl_rd),
        .ctl_we(ctl_we), .trig_we(trig_we), .clr_we(clr_we), .rdata(reg_rdata)
    );

    corepwr_trig #(
        .TRIG_W(TRIG_W), .CORE_BIT(CORE_BIT), .RST_VAL('1)
    ) trig_i (
        .clk(clk), .rst(rst), .set_we(trig_we), .clr_we(clr_we),
        .wdata(reg_wdata[TRIG_W-1:0]), .trig_q(trig_q),
        .assert_evt(assert_evt), .release_evt(release_evt)
    );

    corepwr_core core_i (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .wdata(reg_wdata[7:0]),
        .assert_evt(assert_evt), .release_evt(release_evt),
        .ctl_rd(ctl_rd), .pwr(pwr)
    );

    assign core_run      = pwr.run;
    assign pwr_on_pulse  = pwr.on;
    assign pwr_off_pulse = pwr.off;

    // R10
    ctl_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_CTL) |-> (reg_rdata[DATA_W-1:CTL_W] == '0 && !reg_rdata[0]));
endmodule

// File: tb/corepwr_ctl_tb_top.sv
`timescale 1ns/1ps
module corepwr_ctl_tb_top;
    localparam logic [11:0] A_CTL = 12'h160, A_TRIG = 12'h220, A_CLR = 12'h224, A_BAD = 12'h100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        core_run, pwr_on_pulse, pwr_off_pulse;

    always #4 clk = ~clk;

    corepwr_ctl dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_run(core_run),
        .pwr_on_pulse(pwr_on_pulse), .pwr_off_pulse(pwr_off_pulse)
    );

    typedef struct {
        string       req;
        bit          is_rd;
        logic [31:0] exp;
        int          due;
    } item_t;

    item_t sb_q[$];
    int    pcnt = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always @(posedge clk) pcnt <= pcnt + 1;

    // monitor: compare due items away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == pcnt) begin
            item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_rd ? reg_rdata : {29'd0, pwr_on_pulse, pwr_off_pulse, core_run};
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: %s actual 0x%0h expected 0x%0h", it.req,
                         it.is_rd ? "read" : "on/off/run", act, it.exp);
            end
        end
    end

    task automatic push(string req, bit is_rd, logic [31:0] exp, int due);
        item_t it;
        it.req = req; it.is_rd = is_rd; it.exp = exp; it.due = due;
        sb_q.push_back(it);
    endtask

    // exp_pwr = {on, off, run} in the cycle after the write
    task automatic wr(logic [11:0] a, logic [31:0] d, logic [2:0] exp_pwr, string req);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        push(req, 1'b0, {29'd0, exp_pwr}, pcnt + 1);
        push(req, 1'b0, {29'd0, 2'b00, exp_pwr[0]}, pcnt + 2);
        @(posedge clk); #1;
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string req);
        @(posedge clk); #1;
        reg_addr = a;
        push(req, 1'b1, exp, pcnt);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        rd(A_CTL, 32'h7FE, "R1");
        rd(A_TRIG, 32'h1FFF, "R1");
        push("R1", 1'b0, 32'h0, pcnt + 1);
        // R10 unmapped offset
        rd(A_BAD, 32'h0, "R10");
        wr(A_BAD, 32'hFFFF_FFFF, 3'b000, "R10");
        rd(A_CTL, 32'h7FE, "R10");
        rd(A_TRIG, 32'h1FFF, "R10");
        // R7 release while held
        wr(A_CLR, 32'h200, 3'b000, "R7");
        rd(A_CTL, 32'h3FE, "R7");
        rd(A_TRIG, 32'h1DFF, "R3");
        rd(A_CLR, 32'h0, "R3");
        // R3 release of a bit already clear does nothing
        wr(A_CLR, 32'h200, 3'b000, "R3");
        rd(A_CTL, 32'h3FE, "R3");
        // R8 enable releases hold and powers on
        wr(A_CTL, 32'h3, 3'b101, "R8");
        rd(A_CTL, 32'h002, "R8");
        // R9 enable while running: no pulse
        wr(A_CTL, 32'h1, 3'b001, "R9");
        rd(A_CTL, 32'h000, "R9");
        // R2 trigger without hold request
        wr(A_TRIG, 32'h200, 3'b001, "R2");
        rd(A_CTL, 32'h500, "R2");
        rd(A_TRIG, 32'h1FFF, "R2");
        // R6 release without hold, core already running
        wr(A_CLR, 32'h200, 3'b001, "R6");
        rd(A_CTL, 32'h000, "R6");
        // R4 trigger with hold request powers off
        wr(A_CTL, 32'h2, 3'b001, "R10");
        wr(A_TRIG, 32'h200, 3'b010, "R4");
        rd(A_CTL, 32'h702, "R4");
        wr(A_CLR, 32'h200, 3'b000, "R7");
        rd(A_CTL, 32'h302, "R7");
        // R5 clearing hold request drops hold status
        wr(A_CTL, 32'h0, 3'b000, "R5");
        rd(A_CTL, 32'h100, "R5");
        wr(A_CTL, 32'h1, 3'b101, "R8");
        rd(A_CTL, 32'h000, "R8");
        // R6 release powers on a stopped, not-held core
        wr(A_TRIG, 32'h200, 3'b001, "R6");
        wr(A_CTL, 32'h2, 3'b001, "R6");
        wr(A_TRIG, 32'h200, 3'b010, "R6");
        wr(A_CTL, 32'h0, 3'b000, "R6");
        wr(A_CLR, 32'h200, 3'b101, "R6");
        rd(A_CTL, 32'h000, "R6");
        // R2 zeros and high bits have no effect
        wr(A_TRIG, 32'h0, 3'b001, "R2");
        wr(A_TRIG, 32'hFFFF_E000, 3'b001, "R2");
        rd(A_TRIG, 32'h1DFF, "R2");
        rd(A_CTL, 32'h000, "R2");
        // R3 release clears all set bits in the low 13
        wr(A_CLR, 32'hFFFF_FFFF, 3'b001, "R3");
        rd(A_TRIG, 32'h0, "R3");
        wr(A_TRIG, 32'hFFFF_FFFF, 3'b001, "R2");
        rd(A_TRIG, 32'h1FFF, "R2");
        rd(A_CTL, 32'h500, "R2");
        // R10 status bits and upper bits ignore writes, bits 2..7 stored
        wr(A_CTL, 32'hFFFF_F700, 3'b001, "R10");
        rd(A_CTL, 32'h500, "R10");
        wr(A_CTL, 32'h0000_00FC, 3'b001, "R10");
        rd(A_CTL, 32'h5FC, "R10");
        repeat (4) @(posedge clk);
        if (sb_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: %0d items pending, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule